// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Controller

This block is the trap-entry stage of a small 32-bit core that runs only at the highest privilege level. It owns the machine status, interrupt-enable, interrupt-pending, trap-vector, exception-PC, cause and trap-value registers, plus a sleep flag used by the wait-for-interrupt instruction. The decode and execute logic lives elsewhere. That logic presents one step per cycle on `step_i`, along with the PC of the instruction and any synchronous exception it raised.

In each step the controller decides whether a trap is taken. A pending and enabled timer interrupt has the highest priority. Next comes a misaligned fetch address, found here from the PC itself. Last comes an exception requested by the core. On a trap, `trap_o` pulses in the same cycle and `redirect_pc_o` carries the vector base. At the following clock edge the cause, trap value and exception PC are recorded and the global interrupt enable is stacked. A wait-for-interrupt request puts the core to sleep, and `stall_o` stays high until an interrupt trap wakes it. A small CSR port gives software read and write access to the registers.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset, status reads 0x0000_1800 (previous-privilege field bits 12:11 = 3 for machine mode, enables clear), interrupt-enable, interrupt-pending, exception-PC, cause and trap-value read zero, the vector reads `RESET_TVEC`, and `stall_o` and `trap_o` are low.
- R2: A timer interrupt is taken only when pending bit 7, enable bit 7 and status bit 3 are all set and a step is presented or the core is asleep; `trap_o` then rises in that same cycle.
- R3: A taken timer interrupt writes cause 0x8000_0007 (bit 31 marks an interrupt) and writes trap value zero.
- R4: When an interrupt and an exception fall in the same step, the interrupt is taken and the exception is dropped.
- R5: A step whose PC has nonzero bits 1:0 traps with cause 0 and trap value equal to the full PC. This check wins over a requested exception.
- R6: A requested exception traps with its 4-bit code zero-extended into the cause register and with `exc_tval_i` as the trap value. The codes are 0 misaligned fetch, 1 fetch fault, 2 illegal instruction, 3 breakpoint, 4/5 load misaligned/fault, 6/7 store misaligned/fault, 8/9/11 environment call from user/supervisor/machine, and 12/13/15 page faults.
- R7: On any trap, `redirect_pc_o` is the vector base. At the next edge the exception PC takes the PC with bits 1:0 cleared, status bit 7 takes the old bit 3, and status bit 3 is cleared.
- R8: A step with `wfi_req_i` and no trap sets the sleep flag, and `stall_o` is high from the next cycle. While asleep, steps and exceptions are ignored and the flag holds until an interrupt is taken.
- R9: An interrupt taken while asleep clears the flag, and `stall_o` falls one cycle later. While status bit 3 is clear the core stays asleep, even with the timer pending.
- R10: Writes to the pending register have no effect. Its bit 7 follows `timer_irq_i` one cycle later.
- R11: Only status bits 3 and 7 and enable bit 7 are writable. Vector and exception-PC bits 1:0 read zero. CSR addresses are 0x300 status, 0x304 enable, 0x305 vector, 0x341 exception PC, 0x342 cause, 0x343 trap value and 0x344 pending.
- R12: A CSR write in the same cycle as a trap is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One instruction step presented this cycle |
| pc_i | input | XLEN | PC of the stepped instruction |
| exc_valid_i | input | 1 | Synchronous exception requested |
| exc_cause_i | input | 4 | Exception code |
| exc_tval_i | input | XLEN | Exception trap value |
| wfi_req_i | input | 1 | Stepped instruction is wait-for-interrupt |
| timer_irq_i | input | 1 | Timer interrupt level |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| trap_o | output | 1 | Trap taken this cycle |
| redirect_pc_o | output | XLEN | Trap vector base |
| stall_o | output | 1 | Core asleep waiting for an interrupt |

## Verification
The bench builds the block with XLEN = 32 and a nonzero RESET_TVEC of 0x40. A nonzero default lets the reset check tell a correct vector reset from a cleared register. The full-width build makes both the interrupt flag in bit 31 of the cause and the PC alignment bits visible at the ports. The vector is also programmed with its low bits set, so the masking and the redirect target can be told apart from the reset value.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int CAUSE_W = 4;

  localparam logic [11:0] CSR_MSTATUS = 12'h300;
  localparam logic [11:0] CSR_MIE     = 12'h304;
  localparam logic [11:0] CSR_MTVEC   = 12'h305;
  localparam logic [11:0] CSR_MEPC    = 12'h341;
  localparam logic [11:0] CSR_MCAUSE  = 12'h342;
  localparam logic [11:0] CSR_MTVAL   = 12'h343;
  localparam logic [11:0] CSR_MIP     = 12'h344;

  localparam int ST_MIE_BIT  = 3;
  localparam int ST_MPIE_BIT = 7;
  localparam int ST_MPP_LO   = 11;
  localparam int IRQ_TIMER   = 7;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [CAUSE_W-1:0] {
    EXC_FETCH_MISALIGN = 4'd0,
    EXC_FETCH_FAULT    = 4'd1,
    EXC_ILLEGAL        = 4'd2,
    EXC_BREAK          = 4'd3,
    EXC_LOAD_MISALIGN  = 4'd4,
    EXC_LOAD_FAULT     = 4'd5,
    EXC_STORE_MISALIGN = 4'd6,
    EXC_STORE_FAULT    = 4'd7,
    EXC_ECALL_U        = 4'd8,
    EXC_ECALL_S        = 4'd9,
    EXC_ECALL_M        = 4'd11,
    EXC_FETCH_PAGE     = 4'd12,
    EXC_LOAD_PAGE      = 4'd13,
    EXC_STORE_PAGE     = 4'd15
  } exc_code_e;
endpackage

// File: rtl/mtrap_cause_sel.sv
module mtrap_cause_sel
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               wait_i,
  input  logic               irq_pend_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_tval_i,
  output logic               take_irq_o,
  output logic               take_exc_o,
  output logic [XLEN-1:0]    cause_o,
  output logic [XLEN-1:0]    tval_o
);
  localparam int ALIGN_W = 2;
  localparam logic [XLEN-1:0] IRQ_CAUSE = {1'b1, (XLEN-1)'(IRQ_TIMER)};
  localparam logic [XLEN-1:0] MIS_CAUSE = XLEN'(EXC_FETCH_MISALIGN);

  logic fetch_ok, pc_mis, req_exc;

  assign fetch_ok   = step_i & ~wait_i;
  assign pc_mis     = fetch_ok & (|pc_i[ALIGN_W-1:0]);
  assign req_exc    = fetch_ok & exc_valid_i;
  assign take_irq_o = irq_pend_i & (step_i | wait_i);
  assign take_exc_o = ~take_irq_o & (pc_mis | req_exc);

  // priority: interrupt, fetch alignment, requested exception
  always_comb begin
    cause_o = {{(XLEN-CAUSE_W){1'b0}}, exc_cause_i};
    tval_o  = exc_tval_i;
    if (take_irq_o) begin
      cause_o = IRQ_CAUSE;
      tval_o  = '0;
    end else if (pc_mis) begin
      cause_o = MIS_CAUSE;
      tval_o  = pc_i;
    end
  end

  p_irq_beats_exc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_i && step_i && exc_valid_i) |-> (take_irq_o && !take_exc_o && cause_o[XLEN-1]));

  p_sleep_blocks_exc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !irq_pend_i) |-> !(take_irq_o || take_exc_o));
endmodule

// File: rtl/mtrap_wait_ctrl.sv
module mtrap_wait_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic wfi_req_i,
  input  logic trap_i,
  input  logic irq_i,
  output logic wait_o
);
  logic wait_q, sleep_req;

  assign sleep_req = step_i & wfi_req_i & ~wait_q & ~trap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wait_q <= 1'b0;
    else if (irq_i)     wait_q <= 1'b0;
    else if (sleep_req) wait_q <= 1'b1;
  end

  assign wait_o = wait_q;

  p_wfi_sleeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && wfi_req_i && !wait_q && !trap_i) |=> wait_q);

  p_sleep_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !irq_i) |=> wait_q);

  p_irq_wakes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && irq_i) |=> !wait_q);
endmodule

// File: rtl/mtrap_csr_regs.sv
module mtrap_csr_regs
  import mtrap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_TVEC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            timer_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            trap_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] tval_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            irq_pend_o,
  output logic [XLEN-1:0] tvec_o
);
  localparam int BASE_LSB = 2;

  logic                     st_mie_q, st_mpie_q, mtie_q, mtip_q;
  logic [XLEN-1:BASE_LSB]   mtvec_q, mepc_q;
  logic [XLEN-1:0]          mcause_q, mtval_q;
  logic                     unused_pc;

  assign unused_pc = ^pc_i[BASE_LSB-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_mie_q  <= 1'b0;
      st_mpie_q <= 1'b0;
      mtie_q    <= 1'b0;
      mtip_q    <= 1'b0;
      mtvec_q   <= RESET_TVEC[XLEN-1:BASE_LSB];
      mepc_q    <= '0;
      mcause_q  <= '0;
      mtval_q   <= '0;
    end else begin
      mtip_q <= timer_i;
      if (trap_i) begin
        st_mpie_q <= st_mie_q;
        st_mie_q  <= 1'b0;
        mepc_q    <= pc_i[XLEN-1:BASE_LSB];
        mcause_q  <= cause_i;
        mtval_q   <= tval_i;
      end else if (csr_we_i) begin
        unique case (csr_addr_i)
          CSR_MSTATUS: begin
            st_mie_q  <= csr_wdata_i[ST_MIE_BIT];
            st_mpie_q <= csr_wdata_i[ST_MPIE_BIT];
          end
          CSR_MIE:    mtie_q   <= csr_wdata_i[IRQ_TIMER];
          CSR_MTVEC:  mtvec_q  <= csr_wdata_i[XLEN-1:BASE_LSB];
          CSR_MEPC:   mepc_q   <= csr_wdata_i[XLEN-1:BASE_LSB];
          CSR_MCAUSE: mcause_q <= csr_wdata_i;
          CSR_MTVAL:  mtval_q  <= csr_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    unique case (csr_addr_i)
      CSR_MSTATUS: begin
        csr_rdata_o[ST_MIE_BIT]               = st_mie_q;
        csr_rdata_o[ST_MPIE_BIT]              = st_mpie_q;
        csr_rdata_o[ST_MPP_LO+1:ST_MPP_LO]    = PRIV_M;
      end
      CSR_MIE:    csr_rdata_o[IRQ_TIMER] = mtie_q;
      CSR_MIP:    csr_rdata_o[IRQ_TIMER] = mtip_q;
      CSR_MTVEC:  csr_rdata_o = {mtvec_q, {BASE_LSB{1'b0}}};
      CSR_MEPC:   csr_rdata_o = {mepc_q, {BASE_LSB{1'b0}}};
      CSR_MCAUSE: csr_rdata_o = mcause_q;
      CSR_MTVAL:  csr_rdata_o = mtval_q;
      default: ;
    endcase
  end

  assign irq_pend_o = mtip_q & mtie_q & st_mie_q;
  assign tvec_o     = {mtvec_q, {BASE_LSB{1'b0}}};

  p_trap_stacks_mie_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (!st_mie_q && st_mpie_q == $past(st_mie_q)
                && mepc_q == $past(pc_i[XLEN-1:BASE_LSB])));

  p_irq_record_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && cause_i[XLEN-1]) |=> (mcause_q == $past(cause_i) && mtval_q == '0));

  p_mip_tracks_timer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mtip_q == $past(timer_i)));

  p_trap_drops_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && csr_we_i) |=> $stable(mtvec_q));
endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
  import mtrap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_TVEC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_tval_i,
  input  logic               wfi_req_i,
  input  logic               timer_irq_i,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               trap_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               stall_o
);
  logic            irq_pend, wait_q, take_irq, take_exc, trap;
  logic [XLEN-1:0] cause, tval, tvec;

  assign trap = take_irq | take_exc;

  mtrap_cause_sel #(.XLEN(XLEN)) u_cause_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .wait_i      (wait_q),
    .irq_pend_i  (irq_pend),
    .pc_i        (pc_i),
    .exc_valid_i (exc_valid_i),
    .exc_cause_i (exc_cause_i),
    .exc_tval_i  (exc_tval_i),
    .take_irq_o  (take_irq),
    .take_exc_o  (take_exc),
    .cause_o     (cause),
    .tval_o      (tval)
  );

  mtrap_wait_ctrl u_wait_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .wfi_req_i (wfi_req_i),
    .trap_i    (trap),
    .irq_i     (take_irq),
    .wait_o    (wait_q)
  );

  mtrap_csr_regs #(.XLEN(XLEN), .RESET_TVEC(RESET_TVEC)) u_csr_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .timer_i     (timer_irq_i),
    .csr_we_i    (csr_we_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .trap_i      (trap),
    .cause_i     (cause),
    .tval_i      (tval),
    .pc_i        (pc_i),
    .irq_pend_o  (irq_pend),
    .tvec_o      (tvec)
  );

  assign trap_o        = trap;
  assign redirect_pc_o = tvec;
  assign stall_o       = wait_q;
endmodule

// File: tb/mtrap_ctrl_bench.sv
module mtrap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] RST_VEC = 32'h0000_0040;
  localparam logic [31:0] VEC = 32'h8000_0100;
  localparam logic [11:0] A_ST = 12'h300, A_IE = 12'h304, A_TV = 12'h305,
                          A_EPC = 12'h341, A_CA = 12'h342, A_VAL = 12'h343, A_IP = 12'h344;

  localparam int NV = 6;
  localparam logic [31:0] T_PC [NV] = '{32'h1000, 32'h1004, 32'h2002, 32'h3001, 32'h4000, 32'h5008};
  localparam logic        T_EV [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [3:0]  T_CA [NV] = '{4'd2, 4'd11, 4'd5, 4'd0, 4'd15, 4'd3};
  localparam logic [31:0] T_TV [NV] = '{32'hDEAD_BEEF, 32'h0, 32'h55, 32'h0, 32'hCAFE_0000, 32'h5008};
  localparam logic [31:0] E_CA [NV] = '{32'd2, 32'd11, 32'd0, 32'd0, 32'd15, 32'd3};
  localparam logic [31:0] E_TV [NV] = '{32'hDEAD_BEEF, 32'h0, 32'h2002, 32'h3001, 32'hCAFE_0000, 32'h5008};
  localparam logic [31:0] E_PC [NV] = '{32'h1000, 32'h1004, 32'h2000, 32'h3000, 32'h4000, 32'h5008};

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 0, exc_v = 0, wfi = 0, timer = 0, csr_we = 0;
  logic [31:0] pc = '0, exc_tval = '0, csr_wdata = '0, csr_rdata, redir;
  logic [3:0]  exc_cause = '0;
  logic [11:0] csr_addr = '0;
  logic trap, stall;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtrap_ctrl #(.XLEN(XLEN), .RESET_TVEC(RST_VEC)) u_mtrap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .pc_i(pc), .exc_valid_i(exc_v),
    .exc_cause_i(exc_cause), .exc_tval_i(exc_tval), .wfi_req_i(wfi), .timer_irq_i(timer),
    .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .trap_o(trap), .redirect_pc_o(redir), .stall_o(stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic do_step(input logic [31:0] p, input logic ev, input logic [3:0] c,
                         input logic [31:0] tv, input logic w, output logic t, output logic [31:0] rp);
    @(negedge clk);
    step = 1'b1; pc = p; exc_v = ev; exc_cause = c; exc_tval = tv; wfi = w;
    #1;
    t = trap; rp = redir;
    @(negedge clk);
    step = 1'b0; exc_v = 1'b0; wfi = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, rp, saved;
    logic t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    csr_rd(A_ST, d);  chk("R1 mstatus", d, 32'h1800);
    csr_rd(A_IE, d);  chk("R1 mie", d, 0);
    csr_rd(A_IP, d);  chk("R1 mip", d, 0);
    csr_rd(A_TV, d);  chk("R1 mtvec", d, RST_VEC);
    csr_rd(A_EPC, d); chk("R1 mepc", d, 0);
    csr_rd(A_CA, d);  chk("R1 mcause", d, 0);
    csr_rd(A_VAL, d); chk("R1 mtval", d, 0);
    chk("R1 stall", 32'(stall), 0);
    chk("R1 trap", 32'(trap), 0);

    // R11 write masks
    csr_wr(A_IE, 32'hFFFF_FFFF);  csr_rd(A_IE, d); chk("R11 mie mask", d, 32'h80);
    csr_wr(A_ST, 32'hFFFF_FFFF);  csr_rd(A_ST, d); chk("R11 mstatus mask", d, 32'h1888);
    csr_wr(A_ST, 32'h0);          csr_rd(A_ST, d); chk("R11 mstatus clear", d, 32'h1800);
    csr_wr(A_TV, 32'h8000_0103);  csr_rd(A_TV, d); chk("R11 mtvec align", d, VEC);

    // R5 R6 R7 exception table
    for (int i = 0; i < NV; i++) begin
      do_step(T_PC[i], T_EV[i], T_CA[i], T_TV[i], 1'b0, t, rp);
      chk("R6 trap taken", 32'(t), 1);
      chk("R7 redirect", rp, VEC);
      csr_rd(A_CA, d);  chk("R5/R6 mcause", d, E_CA[i]);
      csr_rd(A_VAL, d); chk("R5/R6 mtval", d, E_TV[i]);
      csr_rd(A_EPC, d); chk("R7 mepc", d, E_PC[i]);
    end

    // R12 CSR write dropped on trap
    @(negedge clk);
    step = 1; pc = 32'h6000; exc_v = 1; exc_cause = 4'd2; exc_tval = 0;
    csr_we = 1; csr_addr = A_TV; csr_wdata = 32'h9000;
    @(negedge clk);
    step = 0; exc_v = 0; csr_we = 0;
    csr_rd(A_TV, d); chk("R12 mtvec kept", d, VEC);
    csr_rd(A_CA, d); chk("R12 cause written", d, 2);

    // R10 mip is read-only and follows the timer
    csr_wr(A_IP, 32'h80); csr_rd(A_IP, d); chk("R10 mip write ignored", d, 0);
    @(negedge clk); timer = 1;
    @(negedge clk); csr_rd(A_IP, d); chk("R10 mip follows timer", d, 32'h80);
    csr_wr(A_IP, 32'h0); csr_rd(A_IP, d); chk("R10 mip clear ignored", d, 32'h80);

    // R2 all three bits required, plus a step
    do_step(32'h100, 0, 0, 0, 0, t, rp); chk("R2 no trap with MIE off", 32'(t), 0);
    csr_wr(A_IE, 0); csr_wr(A_ST, 32'h8);
    do_step(32'h100, 0, 0, 0, 0, t, rp); chk("R2 no trap with enable off", 32'(t), 0);
    csr_wr(A_IE, 32'h80);
    #1; chk("R2 no trap without step", 32'(trap), 0);
    // R4 interrupt beats exception
    do_step(32'h200, 1, 4'd2, 32'h77, 0, t, rp);
    chk("R2 interrupt taken", 32'(t), 1);
    csr_rd(A_CA, d);  chk("R3 R4 interrupt cause", d, 32'h8000_0007);
    csr_rd(A_VAL, d); chk("R3 mtval zero", d, 0);
    csr_rd(A_EPC, d); chk("R7 irq mepc", d, 32'h200);
    csr_rd(A_ST, d);  chk("R7 mstatus stacked", d, 32'h1880);

    // R8 R9 sleep and wake
    @(negedge clk); timer = 0;
    @(negedge clk);
    csr_wr(A_ST, 32'h8);
    do_step(32'h300, 0, 0, 0, 1, t, rp); chk("R8 wfi no trap", 32'(t), 0);
    chk("R8 stall set", 32'(stall), 1);
    csr_rd(A_CA, saved);
    do_step(32'h304, 1, 4'd3, 0, 0, t, rp); chk("R8 exception ignored asleep", 32'(t), 0);
    csr_rd(A_CA, d); chk("R8 mcause unchanged", d, saved);
    chk("R8 stall held", 32'(stall), 1);
    @(negedge clk); pc = 32'h308; timer = 1;
    @(negedge clk); #1;
    chk("R9 wake trap", 32'(trap), 1);
    chk("R9 stall before wake edge", 32'(stall), 1);
    @(negedge clk);
    chk("R9 stall cleared", 32'(stall), 0);
    csr_rd(A_CA, d);  chk("R9 wake cause", d, 32'h8000_0007);
    csr_rd(A_EPC, d); chk("R9 wake mepc", d, 32'h308);

    // R9 stays asleep while MIE clear
    do_step(32'h400, 0, 0, 0, 1, t, rp); chk("R9 wfi with MIE off", 32'(t), 0);
    repeat (5) @(negedge clk);
    chk("R9 still asleep", 32'(stall), 1);
    csr_wr(A_ST, 32'h8);
    #1; chk("R9 wake after enable", 32'(trap), 1);
    @(negedge clk);
    chk("R9 awake", 32'(stall), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule